// File: doc/BRIEF.md
# Storage Sweep Fill and Verify Engine

This maintenance engine exercises a word-organized storage array through a single synchronous memory port. Once a fill request arrives while the machine is offline, it starts an endless ascending sweep over every address. Each address gets a write slot and then a read slot. While the fill request is held, the write slot stores the operator's entry pattern, with an odd parity bit added. The word read back in the read slot is checked for parity. If the word was written in that same visit, it is also compared against the pattern that was written.

Releasing the fill request stops the writes, but the sweep keeps reading and checking until the synchronous reset (machine reset). When stop-on-error is set, the first failing word freezes the engine. Its address and raw stored word are held in capture registers until reset. Outside a sweep, a single-step strobe writes the pattern to one selected address, then reads that word back and checks it.

The memory is expected to register its read data: `mem_rdata` holds the word at the address presented one edge earlier.

Top module: `scanfv_top`

## Requirements
- R1: After reset, `scan_active`, `mem_we`, `chk_valid`, `par_err`, `cmp_err`, `err_hold`, `halted`, `cap_addr` and `cap_word` are all zero.
- R2: A sweep starts only when `cload` is high while `offline` is high. `cload` with `offline` low starts nothing and writes nothing.
- R3: Every write stores `{parity, pattern}`, with the data in bits 34:0 and the parity bit in bit 35. The parity bit makes the number of ones in all 36 bits odd.
- R4: The sweep visits addresses in ascending order and wraps from DEPTH-1 to 0. Each address gets one write slot and then one read slot of the same address.
- R5: After `cload` falls, the sweep continues with no writes until reset.
- R6: Each read produces one `chk_valid` pulse. `par_err` is set with it when the stored word holds an even number of ones.
- R7: `cmp_err` is raised only for a word written in the same visit whose read data bits differ from the pattern written. A read with no preceding write is checked for parity only.
- R8: `err_hold` sets on any parity or compare error and stays set until reset. Without stop-on-error the sweep keeps running.
- R9: With `stop_on_err` high, the first failing read loads its address into `cap_addr` and its 36-bit word into `cap_word` and sets `halted`. After that, no memory writes or new check results occur until reset.
- R10: While idle, a one-cycle `sstep` with `sload_en` high writes the pattern to `sel_addr` only, then reads that word back and checks it. A step is ignored during a sweep, while halted, or with `sload_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high machine reset |
| entry_pat | input | DATA_W | Operator entry pattern |
| cload | input | 1 | Continuous fill request (held) |
| offline | input | 1 | Machine is offline; qualifies fill |
| stop_on_err | input | 1 | Freeze on first failing word |
| sstep | input | 1 | Single-step strobe, one cycle |
| sload_en | input | 1 | Arms the single-step write |
| sel_addr | input | ADDR_W | Target address for single step |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W+1 | Word written, parity in MSB |
| mem_rdata | input | DATA_W+1 | Registered read data |
| scan_active | output | 1 | Sweep running |
| chk_valid | output | 1 | A check result is presented |
| par_err | output | 1 | Parity failure for this check |
| cmp_err | output | 1 | Compare failure for this check |
| err_hold | output | 1 | Sticky error flag |
| halted | output | 1 | Frozen by stop-on-error |
| cap_addr | output | ADDR_W | Captured failing address |
| cap_word | output | DATA_W+1 | Captured failing word |

## Verification
The bench first fills the array with one pattern and checks that every stored word carries that pattern and a matching odd parity bit. It then changes the pattern while the sweep is only reading; this separates a compare that correctly waits for a write from one that runs on every read. A single data-bit flip injected into the model must raise a parity error with no compare error. A double-bit write fault keeps the parity intact but must fail the compare, which separates the two checks and also drives the stop-and-capture path. A single-step run is checked against an untouched neighbouring word, showing that exactly one address was written.

// File: rtl/scanfv_pkg.sv
package scanfv_pkg;
  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_SCAN = 2'd1,
    M_STEP = 2'd2,
    M_HALT = 2'd3
  } mode_e;

  localparam bit PAR_ODD = 1'b1;
endpackage

// File: rtl/scanfv_parity.sv
module scanfv_parity #(
  parameter int W   = 35,
  parameter bit ODD = 1'b1
) (
  input  logic [W-1:0] data,
  output logic         par
);
  generate
    if (ODD) begin : g_odd
      assign par = ~(^data);
    end else begin : g_even
      assign par = ^data;
    end
  endgenerate
endmodule

// File: rtl/scanfv_seq.sv
module scanfv_seq
  import scanfv_pkg::*;
#(
  parameter int DATA_W = 35,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pattern,
  input  logic              pat_par,
  input  logic              cload,
  input  logic              offline,
  input  logic              sstep,
  input  logic              sload_en,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic              halt_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W:0]   mem_wdata,
  output logic              scan_active,
  output logic              rd_v,
  output logic              rd_wr,
  output logic [DATA_W-1:0] rd_pat
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  mode_e             mode;
  logic              phase;
  logic [ADDR_W-1:0] addr_cnt;
  logic              wr_flag;
  logic [DATA_W-1:0] pat_q;
  logic              load_ok;

  assign load_ok     = cload & offline;
  assign scan_active = (mode == M_SCAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= M_IDLE;
      phase     <= 1'b0;
      addr_cnt  <= '0;
      wr_flag   <= 1'b0;
      pat_q     <= '0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      rd_v      <= 1'b0;
      rd_wr     <= 1'b0;
      rd_pat    <= '0;
    end else begin
      mem_we <= 1'b0;
      rd_v   <= 1'b0;
      if (halt_i) begin
        mode <= M_HALT;
      end else begin
        case (mode)
          M_IDLE: begin
            if (load_ok) begin
              mode     <= M_SCAN;
              phase    <= 1'b0;
              addr_cnt <= '0;
            end else if (sstep && sload_en) begin
              mem_addr  <= sel_addr;
              mem_we    <= 1'b1;
              mem_wdata <= {pat_par, pattern};
              wr_flag   <= 1'b1;
              pat_q     <= pattern;
              mode      <= M_STEP;
            end
          end
          M_STEP: begin
            rd_v   <= 1'b1;
            rd_wr  <= wr_flag;
            rd_pat <= pat_q;
            mode   <= M_IDLE;
          end
          M_SCAN: begin
            mem_addr <= addr_cnt;
            if (!phase) begin
              mem_we    <= load_ok;
              mem_wdata <= {pat_par, pattern};
              wr_flag   <= load_ok;
              pat_q     <= pattern;
              phase     <= 1'b1;
            end else begin
              rd_v     <= 1'b1;
              rd_wr    <= wr_flag;
              rd_pat   <= pat_q;
              phase    <= 1'b0;
              addr_cnt <= (addr_cnt == LAST) ? '0 : addr_cnt + 1'b1;
            end
          end
          default: mode <= M_HALT;
        endcase
      end
    end
  end
endmodule

// File: rtl/scanfv_check.sv
module scanfv_check
  import scanfv_pkg::*;
#(
  parameter int DATA_W = 35,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_v,
  input  logic              rd_wr,
  input  logic [DATA_W-1:0] rd_pat,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W:0]   mem_rdata,
  input  logic              stop_on_err,
  output logic              chk_valid,
  output logic              par_err,
  output logic              cmp_err,
  output logic              err_hold,
  output logic              halted,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W:0]   cap_word
);
  logic              t_v;
  logic              t_wr;
  logic [DATA_W-1:0] t_pat;
  logic [ADDR_W-1:0] t_addr;
  logic              exp_par;
  logic              bad_par;
  logic              bad_cmp;
  logic              live;

  scanfv_parity #(.W(DATA_W), .ODD(PAR_ODD)) u_rpar (
    .data (mem_rdata[DATA_W-1:0]),
    .par  (exp_par)
  );

  assign live    = t_v & ~halted;
  assign bad_par = (exp_par != mem_rdata[DATA_W]);
  assign bad_cmp = t_wr & (mem_rdata[DATA_W-1:0] != t_pat);

  always_ff @(posedge clk) begin
    if (rst) begin
      t_v    <= 1'b0;
      t_wr   <= 1'b0;
      t_pat  <= '0;
      t_addr <= '0;
    end else begin
      t_v    <= rd_v;
      t_wr   <= rd_wr;
      t_pat  <= rd_pat;
      t_addr <= rd_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_valid <= 1'b0;
      par_err   <= 1'b0;
      cmp_err   <= 1'b0;
      err_hold  <= 1'b0;
      halted    <= 1'b0;
      cap_addr  <= '0;
      cap_word  <= '0;
    end else begin
      chk_valid <= live;
      par_err   <= live & bad_par;
      cmp_err   <= live & bad_cmp;
      if (live && (bad_par || bad_cmp)) begin
        err_hold <= 1'b1;
        if (stop_on_err) begin
          halted   <= 1'b1;
          cap_addr <= t_addr;
          cap_word <= mem_rdata;
        end
      end
    end
  end
endmodule

// File: rtl/scanfv_top.sv
module scanfv_top
  import scanfv_pkg::*;
#(
  parameter int DATA_W = 35,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] entry_pat,
  input  logic              cload,
  input  logic              offline,
  input  logic              stop_on_err,
  input  logic              sstep,
  input  logic              sload_en,
  input  logic [ADDR_W-1:0] sel_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W:0]   mem_wdata,
  input  logic [DATA_W:0]   mem_rdata,
  output logic              scan_active,
  output logic              chk_valid,
  output logic              par_err,
  output logic              cmp_err,
  output logic              err_hold,
  output logic              halted,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W:0]   cap_word
);
  logic              pat_par;
  logic              rd_v;
  logic              rd_wr;
  logic [DATA_W-1:0] rd_pat;

  scanfv_parity #(.W(DATA_W), .ODD(PAR_ODD)) u_wpar (
    .data (entry_pat),
    .par  (pat_par)
  );

  scanfv_seq #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .pattern     (entry_pat),
    .pat_par     (pat_par),
    .cload       (cload),
    .offline     (offline),
    .sstep       (sstep),
    .sload_en    (sload_en),
    .sel_addr    (sel_addr),
    .halt_i      (halted),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .scan_active (scan_active),
    .rd_v        (rd_v),
    .rd_wr       (rd_wr),
    .rd_pat      (rd_pat)
  );

  scanfv_check #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_v        (rd_v),
    .rd_wr       (rd_wr),
    .rd_pat      (rd_pat),
    .rd_addr     (mem_addr),
    .mem_rdata   (mem_rdata),
    .stop_on_err (stop_on_err),
    .chk_valid   (chk_valid),
    .par_err     (par_err),
    .cmp_err     (cmp_err),
    .err_hold    (err_hold),
    .halted      (halted),
    .cap_addr    (cap_addr),
    .cap_word    (cap_word)
  );
endmodule

// File: rtl/scanfv_sva.sv
module scanfv_sva #(
  parameter int DATA_W = 35,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [DATA_W:0]   mem_wdata,
  input logic              chk_valid,
  input logic              par_err,
  input logic              cmp_err,
  input logic              err_hold,
  input logic              halted,
  input logic [ADDR_W-1:0] cap_addr,
  input logic [DATA_W:0]   cap_word
);
  // R3
  wr_odd_par_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (^mem_wdata));

  // R4
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(mem_addr) < DEPTH);

  // R6
  flag_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (par_err || cmp_err) |-> chk_valid);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_hold |=> err_hold);

  // R8
  halt_implies_err_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> err_hold);

  // R9
  halt_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> !mem_we);

  // R9
  halt_no_check_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> !chk_valid);

  // R9
  cap_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(cap_addr) && $stable(cap_word)));
endmodule

bind scanfv_top scanfv_sva #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .chk_valid (chk_valid),
  .par_err   (par_err),
  .cmp_err   (cmp_err),
  .err_hold  (err_hold),
  .halted    (halted),
  .cap_addr  (cap_addr),
  .cap_word  (cap_word)
);

// File: tb/scanfv_top_tb_top.sv
`timescale 1ns/1ps
module scanfv_top_tb_top;
  localparam int DW = 35;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] entry_pat = '0;
  logic          cload = 1'b0;
  logic          offline = 1'b0;
  logic          stop_on_err = 1'b0;
  logic          sstep = 1'b0;
  logic          sload_en = 1'b0;
  logic [AW-1:0] sel_addr = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW:0]   mem_wdata;
  logic [DW:0]   mem_rdata = '0;
  logic          scan_active, chk_valid, par_err, cmp_err, err_hold, halted;
  logic [AW-1:0] cap_addr;
  logic [DW:0]   cap_word;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  scanfv_top #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .entry_pat(entry_pat), .cload(cload),
    .offline(offline), .stop_on_err(stop_on_err), .sstep(sstep),
    .sload_en(sload_en), .sel_addr(sel_addr), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .scan_active(scan_active), .chk_valid(chk_valid), .par_err(par_err),
    .cmp_err(cmp_err), .err_hold(err_hold), .halted(halted),
    .cap_addr(cap_addr), .cap_word(cap_word)
  );

  // storage model with write fault injection, registered read
  logic [DW:0]   mem [DEPTH];
  logic          flt_en = 1'b0;
  logic [AW-1:0] flt_addr = '0;
  logic [DW:0]   flt_mask = '0;

  always @(posedge clk) begin
    if (mem_we)
      mem[mem_addr] <= mem_wdata ^ ((flt_en && mem_addr == flt_addr) ? flt_mask : '0);
    mem_rdata <= mem[mem_addr];
  end

  // monitor counters, only written here
  int we_cnt = 0, chk_cnt = 0, par_cnt = 0, cmp_cnt = 0;
  int seq_bad = 0, wrap_cnt = 0;
  logic [AW-1:0] last_addr = '0;
  logic          last_scan = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      we_cnt  <= we_cnt + int'(mem_we);
      chk_cnt <= chk_cnt + int'(chk_valid);
      par_cnt <= par_cnt + int'(par_err);
      cmp_cnt <= cmp_cnt + int'(cmp_err);
      if (scan_active && last_scan && mem_addr != last_addr) begin
        if (32'(mem_addr) != (32'(last_addr) + 1) % DEPTH) seq_bad <= seq_bad + 1;
        if (32'(last_addr) == DEPTH - 1 && mem_addr == '0) wrap_cnt <= wrap_cnt + 1;
      end
    end
    last_addr <= mem_addr;
    last_scan <= scan_active;
  end

  function automatic logic [DW:0] enc(input logic [DW-1:0] d);
    return {~(^d), d};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mem_init();
    for (int i = 0; i < DEPTH; i++) mem[i] = enc('0);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cload = 1'b0; offline = 1'b0; stop_on_err = 1'b0;
    sstep = 1'b0; sload_en = 1'b0; flt_en = 1'b0;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(2);
  endtask

  task automatic t_reset();
    check(scan_active == 0, "R1 scan_active", 64'(scan_active), 0);
    check(mem_we == 0 && chk_valid == 0, "R1 we/valid", {mem_we, chk_valid}, 0);
    check({par_err, cmp_err, err_hold, halted} == 0, "R1 flags",
          {par_err, cmp_err, err_hold, halted}, 0);
    check(cap_addr == 0 && cap_word == 0, "R1 capture", 64'(cap_word), 0);
  endtask

  task automatic t_offline_gate();
    int w0 = we_cnt;
    cload = 1'b1; offline = 1'b0;
    wait_cyc(20);
    check(scan_active == 0, "R2 no sweep when online", 64'(scan_active), 0);
    check(we_cnt == w0, "R2 no write when online", 64'(we_cnt - w0), 0);
    cload = 1'b0;
    wait_cyc(2);
  endtask

  task automatic t_fill(input logic [DW-1:0] pat);
    int w0 = we_cnt, c0 = chk_cnt, p0 = par_cnt, m0 = cmp_cnt;
    int s0 = seq_bad, r0 = wrap_cnt;
    bit all_ok = 1'b1;
    entry_pat = pat; offline = 1'b1; cload = 1'b1;
    wait_cyc(2);
    check(scan_active == 1, "R2 sweep started", 64'(scan_active), 1);
    wait_cyc(4 * DEPTH);
    cload = 1'b0;
    wait_cyc(10);
    for (int i = 0; i < DEPTH; i++) if (mem[i] != enc(pat)) all_ok = 1'b0;
    check(all_ok, "R3 every word holds pattern with odd parity", 64'(mem[0]), 64'(enc(pat)));
    check(we_cnt - w0 >= DEPTH, "R3 write count", 64'(we_cnt - w0), DEPTH);
    check(chk_cnt - c0 >= 2 * DEPTH, "R6 checks issued", 64'(chk_cnt - c0), 2 * DEPTH);
    check(par_cnt == p0 && cmp_cnt == m0, "R6 no false error",
          64'(par_cnt - p0 + cmp_cnt - m0), 0);
    check(seq_bad == s0, "R4 ascending order", 64'(seq_bad - s0), 0);
    check(wrap_cnt > r0, "R4 wrap to zero", 64'(wrap_cnt - r0), 1);
  endtask

  task automatic t_release(input logic [DW-1:0] newpat);
    int w0 = we_cnt, c0 = chk_cnt, m0 = cmp_cnt;
    entry_pat = newpat;
    wait_cyc(4 * DEPTH);
    check(scan_active == 1, "R5 sweep continues after release", 64'(scan_active), 1);
    check(we_cnt == w0, "R5 no writes after release", 64'(we_cnt - w0), 0);
    check(chk_cnt > c0, "R5 reads continue", 64'(chk_cnt - c0), 1);
    check(cmp_cnt == m0, "R7 no compare on unwritten reads", 64'(cmp_cnt - m0), 0);
    // R10 step ignored during sweep
    sel_addr = AW'(2); sload_en = 1'b1; sstep = 1'b1;
    wait_cyc(1);
    sstep = 1'b0; sload_en = 1'b0;
    wait_cyc(6);
    check(we_cnt == w0, "R10 step ignored while sweeping", 64'(we_cnt - w0), 0);
  endtask

  task automatic t_parity_fault();
    int p0 = par_cnt, m0 = cmp_cnt;
    @(negedge clk);
    mem[5] = mem[5] ^ 36'h1;
    wait_cyc(4 * DEPTH);
    check(par_cnt > p0, "R6 parity error reported", 64'(par_cnt - p0), 1);
    check(cmp_cnt == m0, "R7 parity fault gives no compare error", 64'(cmp_cnt - m0), 0);
    check(err_hold == 1, "R8 sticky error", 64'(err_hold), 1);
    check(halted == 0 && scan_active == 1, "R8 sweep runs on", {halted, scan_active}, 1);
  endtask

  task automatic t_stop(input logic [DW-1:0] pat);
    int p0, m0, w1, c1;
    logic [DW:0] mask = 36'h88;
    mem_init();
    flt_en = 1'b1; flt_addr = AW'(9); flt_mask = mask;
    stop_on_err = 1'b1; entry_pat = pat;
    p0 = par_cnt; m0 = cmp_cnt;
    offline = 1'b1; cload = 1'b1;
    wait_cyc(4 * DEPTH);
    check(halted == 1, "R9 halted", 64'(halted), 1);
    check(cap_addr == AW'(9), "R9 captured address", 64'(cap_addr), 9);
    check(cap_word == (enc(pat) ^ mask), "R9 captured word", 64'(cap_word),
          64'(enc(pat) ^ mask));
    check(cmp_cnt - m0 == 1, "R7 single compare error", 64'(cmp_cnt - m0), 1);
    check(par_cnt == p0, "R7 double flip keeps parity", 64'(par_cnt - p0), 0);
    w1 = we_cnt; c1 = chk_cnt;
    wait_cyc(20);
    check(we_cnt == w1 && chk_cnt == c1, "R9 no activity while halted",
          64'(we_cnt - w1 + chk_cnt - c1), 0);
    check(err_hold == 1, "R8 sticky with halt", 64'(err_hold), 1);
    do_reset();
    check(halted == 0 && err_hold == 0 && cap_addr == 0 && cap_word == 0,
          "R1 reset clears capture", {halted, err_hold, 60'(cap_word)}, 0);
  endtask

  task automatic t_single(input logic [DW-1:0] pat);
    int w0, c0, e0;
    mem_init();
    entry_pat = pat; sel_addr = AW'(3);
    w0 = we_cnt;
    sstep = 1'b1; sload_en = 1'b0;
    wait_cyc(1);
    sstep = 1'b0;
    wait_cyc(6);
    check(we_cnt == w0, "R10 step without arm ignored", 64'(we_cnt - w0), 0);
    w0 = we_cnt; c0 = chk_cnt; e0 = par_cnt + cmp_cnt;
    sstep = 1'b1; sload_en = 1'b1;
    wait_cyc(1);
    sstep = 1'b0; sload_en = 1'b0;
    wait_cyc(8);
    check(we_cnt - w0 == 1, "R10 exactly one write", 64'(we_cnt - w0), 1);
    check(mem[3] == enc(pat), "R10 target written", 64'(mem[3]), 64'(enc(pat)));
    check(mem[2] == enc('0) && mem[4] == enc('0), "R10 neighbours untouched",
          64'(mem[2]), 64'(enc('0)));
    check(chk_cnt - c0 == 1, "R10 one readback check", 64'(chk_cnt - c0), 1);
    check(par_cnt + cmp_cnt == e0, "R10 readback clean", 64'(par_cnt + cmp_cnt - e0), 0);
    check(scan_active == 0, "R10 returns idle", 64'(scan_active), 0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mem_init();
    do_reset();
    t_reset();
    t_offline_gate();
    t_fill(35'h5A5A51234);
    t_release(35'h12345678F);
    t_parity_fault();
    do_reset();
    t_stop(35'h0F0F0F0F0);
    t_single(35'h3C3C3C3C3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule